// File: doc/BRIEF.md
# AXI Burst Splitter

This block turns one long memory transfer request into a sequence of AXI4 address-channel bursts. A request carries a start byte address, aligned to the bus word, and a length counted in bus words. The block drives address beats carrying the start address, the encoded length, the beat size and the incrementing burst type. It works the same for a read or a write address channel. Both the request side and the address side use a valid/ready handshake.

Each burst is cut to the smallest of three limits. The first is the maximum burst length set at elaboration. The second is a cap that depends on the bus width, so that one burst never moves more than 4 KB and never exceeds the 256-beat limit of the length field. The third is the number of beats left before the next 4 KB address boundary. Whatever remains is issued as further bursts until the request is used up. A single-cycle done pulse then marks the end of the request.

Top module: `axi_burst_splitter`

## Requirements
- R1: While reset is held and directly after it, `ax_valid` is 0, `done` is 0 and `req_ready` is 1.
- R2: A request is taken only while no bursts are pending. `req_ready` is 1 exactly when the block is idle, and a request offered while busy has no effect on the bursts issued.
- R3: No burst has more than min(MAX_BEATS, 256, 4096 / DATA_BYTES) beats.
- R4: No burst crosses a 4 KB address boundary. A burst that reaches the boundary is cut there, and the next burst starts exactly on it.
- R5: The length field `ax_len` equals the burst's beat count minus one. A request is covered by bursts of length min(effective maximum, beats left in the request, beats left in the page), issued in address order. A request shorter than all the limits gives one burst of exactly its length.
- R6: The first burst starts at the request address. After each accepted burst, the address advances by beats × DATA_BYTES.
- R7: `ax_size` is log2(DATA_BYTES), and `ax_burst` is 2'b01 (incrementing).
- R8: While `ax_valid` is 1 and `ax_ready` is 0, `ax_valid`, `ax_addr` and `ax_len` hold their values into the next cycle.
- R9: `done` is 1 for exactly one cycle. That cycle is the one after the handshake of the last burst of a request.
- R10: A request of zero length is accepted, produces no burst, and raises `done` in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Start byte address, aligned to the bus word |
| req_beats | input | CNT_W | Transfer length in bus words |
| ax_valid | output | 1 | Address beat valid |
| ax_ready | input | 1 | Address beat accepted by the downstream channel |
| ax_addr | output | ADDR_W | Burst start address |
| ax_len | output | 8 | Beats in the burst minus one |
| ax_size | output | 3 | log2 of bytes per beat |
| ax_burst | output | 2 | Burst type, always incrementing (2'b01) |
| done | output | 1 | One-cycle pulse after the last burst of a request |

## Verification
The bench sweeps every request length from 0 to 300 beats against six start offsets inside a 4 KB page. The offsets include the first beat, the last beat and points where the page end falls inside a maximum-length burst. A design that ignored the page distance would emit a burst straddling the boundary, and one that got the remainder wrong would drop or duplicate beats at the tail. The address channel is throttled by a pseudo-random ready, which catches a design that moves the address or length while stalled, or that advances on valid alone. Zero-length requests and requests held high while busy check that the done pulse still arrives and that a stray second request is not taken up early.

// File: rtl/burst_split_pkg.sv
package burst_split_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } split_state_e;

    localparam logic [1:0]  BURST_INCR      = 2'b01;
    localparam int unsigned PAGE_BYTES      = 4096;
    localparam int unsigned LEN_FIELD_BEATS = 256;

endpackage

// File: rtl/burst_len_calc.sv
module burst_len_calc
    import burst_split_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned DATA_BYTES = 8,
    parameter int unsigned MAX_BEATS  = 128
) (
    input  logic [11-$clog2(DATA_BYTES):0] beat_in_page,
    input  logic [CNT_W-1:0]               rem_beats,
    output logic [8:0]                     burst_beats
);

    localparam int unsigned PAGE_BEATS = PAGE_BYTES / DATA_BYTES;
    localparam int unsigned WIDTH_CAP  = (PAGE_BEATS < LEN_FIELD_BEATS) ? PAGE_BEATS : LEN_FIELD_BEATS;
    localparam int unsigned EFF_MAX    = (MAX_BEATS < WIDTH_CAP) ? MAX_BEATS : WIDTH_CAP;
    localparam int unsigned CW         = ((CNT_W > 13) ? CNT_W : 13) + 1;

    logic [CW-1:0] to_page_end;
    logic [CW-1:0] rem_ext;
    logic [CW-1:0] limit;
    logic [CW-1:0] chosen;

    // Beats between the current address and the next 4 KB boundary.
    assign to_page_end = CW'(PAGE_BEATS) - CW'(beat_in_page);
    assign rem_ext     = CW'(rem_beats);

    generate
        if (EFF_MAX >= PAGE_BEATS) begin : g_page_bound
            // The page distance never exceeds the cap, so it alone bounds the burst.
            assign limit = to_page_end;
        end else begin : g_param_bound
            logic [CW-1:0] cap_ext;
            assign cap_ext = CW'(EFF_MAX);
            assign limit   = (cap_ext < to_page_end) ? cap_ext : to_page_end;
        end
    endgenerate

    always_comb begin
        chosen      = (rem_ext < limit) ? rem_ext : limit;
        burst_beats = 9'(chosen);
    end

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_split_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned SIZE_LOG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_beats,
    output logic              req_ready,
    input  logic              ax_ready,
    output logic              ax_valid,
    input  logic [8:0]        burst_beats,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_rem,
    output logic              done
);

    typedef struct packed {
        split_state_e      state;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  rem;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    logic [ADDR_W-1:0] step_bytes_d;
    logic [CNT_W-1:0]  step_beats_d;

    always_comb begin
        s_d          = s_q;
        s_d.done     = 1'b0;
        step_beats_d = CNT_W'(burst_beats);
        step_bytes_d = ADDR_W'(burst_beats) << SIZE_LOG;
        case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.addr = req_addr;
                    s_d.rem  = req_beats;
                    if (req_beats == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.state = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (ax_ready) begin
                    s_d.addr = s_q.addr + step_bytes_d;
                    s_d.rem  = s_q.rem - step_beats_d;
                    if (s_q.rem == step_beats_d) begin
                        s_d.state = ST_IDLE;
                        s_d.done  = 1'b1;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.state == ST_IDLE);
    assign ax_valid  = (s_q.state == ST_ISSUE);
    assign cur_addr  = s_q.addr;
    assign cur_rem   = s_q.rem;
    assign done      = s_q.done;

    // R2: while busy the remaining count only shrinks; no new request reloads it.
    a_r2_busy_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_ISSUE) |=> (s_q.rem <= $past(s_q.rem)));

    // R10: an empty request finishes at once without entering the issue state.
    a_r10_empty_request: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.state == ST_IDLE) && req_valid && (req_beats == '0)) |=> (s_q.done && (s_q.state == ST_IDLE)));

endmodule

// File: rtl/axi_burst_splitter.sv
module axi_burst_splitter
    import burst_split_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned DATA_BYTES = 8,
    parameter int unsigned MAX_BEATS  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_beats,
    output logic              ax_valid,
    input  logic              ax_ready,
    output logic [ADDR_W-1:0] ax_addr,
    output logic [7:0]        ax_len,
    output logic [2:0]        ax_size,
    output logic [1:0]        ax_burst,
    output logic              done
);

    localparam int unsigned SIZE_LOG   = $clog2(DATA_BYTES);
    localparam int unsigned PAGE_BEATS = PAGE_BYTES / DATA_BYTES;
    localparam int unsigned WIDTH_CAP  = (PAGE_BEATS < LEN_FIELD_BEATS) ? PAGE_BEATS : LEN_FIELD_BEATS;
    localparam int unsigned EFF_MAX    = (MAX_BEATS < WIDTH_CAP) ? MAX_BEATS : WIDTH_CAP;

    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_rem;
    logic [8:0]        burst_beats;

    burst_seq_ctrl #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .SIZE_LOG(SIZE_LOG)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_beats  (req_beats),
        .req_ready  (req_ready),
        .ax_ready   (ax_ready),
        .ax_valid   (ax_valid),
        .burst_beats(burst_beats),
        .cur_addr   (cur_addr),
        .cur_rem    (cur_rem),
        .done       (done)
    );

    burst_len_calc #(
        .CNT_W     (CNT_W),
        .DATA_BYTES(DATA_BYTES),
        .MAX_BEATS (MAX_BEATS)
    ) u_len (
        .beat_in_page(cur_addr[11:SIZE_LOG]),
        .rem_beats   (cur_rem),
        .burst_beats (burst_beats)
    );

    assign ax_addr  = cur_addr;
    assign ax_len   = 8'(burst_beats - 9'd1);
    assign ax_size  = 3'(SIZE_LOG);
    assign ax_burst = BURST_INCR;

    // Byte offset, inside the 4 KB page, one past the last byte of the burst.
    logic [13:0] span_end;
    assign span_end = 14'(ax_addr[11:0]) + ((14'(ax_len) + 14'd1) << SIZE_LOG);

    // R3: the length never exceeds the effective maximum.
    a_r3_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ax_valid |-> ((32'(ax_len) + 32'd1) <= EFF_MAX));

    // R4: a burst stays inside its 4 KB page.
    a_r4_no_page_cross: assert property (@(posedge clk) disable iff (!rst_n)
        ax_valid |-> (span_end <= 14'd4096));

    // R6: the next burst begins where the accepted one ended.
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_valid && ax_ready) |=>
            (!ax_valid || (ax_addr == ($past(ax_addr) + ((ADDR_W'($past(ax_len)) + ADDR_W'(1)) << SIZE_LOG)))));

    // R8: a stalled address beat holds its content.
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_valid && !ax_ready) |=> (ax_valid && $stable(ax_addr) && $stable(ax_len)));

    // R9: done follows only a final handshake or an empty request.
    a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(ax_valid && ax_ready) || $past(req_valid && req_ready && (req_beats == '0))));

endmodule

// File: tb/tb_axi_burst_splitter.sv
module tb_axi_burst_splitter;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int CNT_W      = 16;
    localparam int DATA_BYTES = 16;
    localparam int MAX_BEATS  = 64;
    localparam int EFF        = 64;   // min(64, 256, 4096/16)
    localparam int LOG_BYTES  = 4;

    logic              clk;
    logic              rst_n;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic [CNT_W-1:0]  req_beats;
    logic              ax_valid;
    logic              ax_ready;
    logic [ADDR_W-1:0] ax_addr;
    logic [7:0]        ax_len;
    logic [2:0]        ax_size;
    logic [1:0]        ax_burst;
    logic              done;

    axi_burst_splitter #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .DATA_BYTES(DATA_BYTES),
        .MAX_BEATS (MAX_BEATS)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_addr (req_addr),
        .req_beats(req_beats),
        .ax_valid (ax_valid),
        .ax_ready (ax_ready),
        .ax_addr  (ax_addr),
        .ax_len   (ax_len),
        .ax_size  (ax_size),
        .ax_burst (ax_burst),
        .done     (done)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int          tests = 0;
    int          fails = 0;
    logic [15:0] lfsr  = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    function automatic int offset_of(input int i);
        case (i)
            0:       return 0;
            1:       return 1;
            2:       return 37;
            3:       return 200;
            4:       return 240;
            default: return 255;
        endcase
    endfunction

    task automatic run_req(input logic [63:0] addr, input int beats, input bit hold);
        logic [63:0] cur;
        int          rem;
        int          b;
        int          page_left;
        int          guard;
        bit          pend;
        bit          stall;
        logic [31:0] s_addr;
        logic [7:0]  s_len;
        step();
        #1;
        chk(done == 1'b0, "R9 done lasts one cycle", done, 0);
        req_valid = 1'b1;
        req_addr  = addr[31:0];
        req_beats = beats[15:0];
        #1;
        chk(req_ready == 1'b1, "R2 idle block offers ready", req_ready, 1);
        step();
        if (hold) begin
            req_addr  = ~addr[31:0];
            req_beats = 16'd5;
        end else begin
            req_valid = 1'b0;
        end
        if (beats == 0) begin
            #1;
            chk(done == 1'b1, "R10 empty request gives done", done, 1);
            chk(ax_valid == 1'b0, "R10 empty request issues no burst", ax_valid, 0);
            req_valid = 1'b0;
            return;
        end
        cur    = addr;
        rem    = beats;
        pend   = 1'b0;
        stall  = 1'b0;
        guard  = 0;
        s_addr = '0;
        s_len  = '0;
        forever begin
            ax_ready = lfsr[0] | lfsr[1];
            #1;
            if (pend) begin
                chk(done == 1'b1, "R9 done after last burst", done, 1);
                chk(ax_valid == 1'b0, "R9 no burst after last", ax_valid, 0);
                chk(req_ready == 1'b1, "R2 idle after last burst", req_ready, 1);
                req_valid = 1'b0;
                break;
            end
            chk(done == 1'b0, "R9 no early done", done, 0);
            if (hold) chk(req_ready == 1'b0, "R2 busy refuses request", req_ready, 0);
            if (stall) begin
                chk(ax_addr == s_addr, "R8 address held on stall", ax_addr, s_addr);
                chk(ax_len == s_len, "R8 length held on stall", ax_len, s_len);
            end
            chk(ax_valid == 1'b1, "R5 burst pending", ax_valid, 1);
            b = rem;
            if (b > EFF) b = EFF;
            page_left = (4096 - int'(cur % 4096)) / DATA_BYTES;
            if (b > page_left) b = page_left;
            chk(ax_addr == cur[31:0], "R6 burst address", ax_addr, cur[31:0]);
            chk(int'(ax_len) == b - 1, "R5 burst length", ax_len, b - 1);
            chk(int'(ax_len) + 1 <= EFF, "R3 length cap", int'(ax_len) + 1, EFF);
            chk(int'(ax_addr % 4096) + (int'(ax_len) + 1) * DATA_BYTES <= 4096,
                "R4 page boundary", int'(ax_addr % 4096) + (int'(ax_len) + 1) * DATA_BYTES, 4096);
            chk(ax_size == 3'(LOG_BYTES), "R7 size field", ax_size, LOG_BYTES);
            chk(ax_burst == 2'b01, "R7 burst type", ax_burst, 1);
            s_addr = ax_addr;
            s_len  = ax_len;
            stall  = ax_valid && !ax_ready;
            if (ax_valid && ax_ready) begin
                cur = cur + 64'(b * DATA_BYTES);
                rem = rem - b;
                if (rem <= 0) pend = 1'b1;
            end
            guard++;
            if (guard > 4000) begin
                chk(1'b0, "R5 request never finished", guard, 0);
                break;
            end
            step();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_addr  = '0;
        req_beats = '0;
        ax_ready  = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(ax_valid == 1'b0, "R1 no burst in reset", ax_valid, 0);
        chk(done == 1'b0, "R1 no done in reset", done, 0);
        chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        rst_n = 1'b1;
        step();
        #1;
        chk(ax_valid == 1'b0, "R1 no burst after reset", ax_valid, 0);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        for (int i = 0; i < 6; i++) begin
            for (int len = 0; len <= 300; len++) begin
                run_req(64'h0003_0000 + 64'(i * 3 * 4096) + 64'(offset_of(i) * DATA_BYTES),
                        len, (len % 7) == 3);
            end
        end
        step();
        #1;
        chk(done == 1'b0, "R9 final done lasts one cycle", done, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule